// File: doc/BRIEF.md
# Serially Reconfigurable Lookup Table

This block is a one-bit-wide logic table with sixteen entries. A four-bit select value picks one entry as a row index, and the chosen bit appears on a single output. At reset the table takes its contents from a sixteen-bit parameter. At run time a configuration port can rewrite the table, one bit per clock.

While the configuration enable is high, each rising clock edge shifts the table by one place. The serial data bit enters entry 0. Every other entry takes the value of the entry below it. The bit that leaves entry 15 is visible on a cascade output, so several tables can be chained into one longer load path. The read path keeps working during a load and always shows the table as it stands.

Because the contents can change, two rows that start out equal may hold different values after a load. Tying a select input to a constant because two rows once matched is therefore not a safe simplification.

Top module: `serial_lut`

## Requirements
- R1: A cycle with `rst` high loads the table from `INIT_BITS`, with parameter bit k becoming entry k.
- R2: `lut_out` equals the entry whose row number is `sel`, counting rows from zero; `sel` = 4'b0001 returns entry 1.
- R3: On a rising edge with `cfg_en` high and `rst` low, entry 0 takes `cfg_din` and entry k takes the former entry k-1 for k from 1 to 15.
- R4: `cascade_out` always shows the present value of entry 15, so during a load it shows the bit shifted out at the next enabled edge.
- R5: With `cfg_en` low, the table holds its contents whatever value `cfg_din` has.
- R6: When `rst` and `cfg_en` are both high in the same cycle, the reset load wins and no shift happens.
- R7: After 16 consecutive enabled edges, entry k holds the bit supplied k edges before the most recent one.
- R8: The read path is combinational, so `lut_out` shows a shifted table in the same cycle that follows the clock edge, with no added latency.
- R9: Two rows that are equal after reset can differ after a single enabled shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the table updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset that loads the initial contents |
| sel | input | 4 | Row index for the read path |
| cfg_en | input | 1 | Enables the shift-in load of the table |
| cfg_din | input | 1 | Serial configuration bit entering entry 0 |
| lut_out | output | 1 | Stored bit at the selected row |
| cascade_out | output | 1 | Present value of the top entry (entry 15) |

## Verification
The table itself is the only register. A reset or a shift is therefore visible on `lut_out` and `cascade_out` one time step after the clock edge that caused it. A change of `sel` alone shows up with no clock at all. The bench drives inputs and then steps its queue-based model at each edge. It compares the outputs a short delay after the edge, and for full-table sweeps it changes `sel` and compares after a settle delay with no edge in between. The boundary checks are the select value 0001, a reset asserted together with an enable, and a full sixteen-bit load checked against the supply order. Two rows that start out equal are checked to diverge after one shift.

// File: rtl/serial_lut_pkg.sv
package serial_lut_pkg;
  localparam int unsigned LUT_ENTRIES = 16;
  localparam int unsigned LUT_SEL_W   = $clog2(LUT_ENTRIES);

  typedef logic [LUT_ENTRIES-1:0] lut_bits_t;
  typedef logic [LUT_SEL_W-1:0]   lut_sel_t;

  typedef enum logic [1:0] {
    UPD_HOLD  = 2'd0,
    UPD_SHIFT = 2'd1,
    UPD_INIT  = 2'd2
  } lut_upd_e;
endpackage

// File: rtl/lut_update_ctrl.sv
module lut_update_ctrl
  import serial_lut_pkg::*;
(
  input  logic     rst,
  input  logic     cfg_en,
  output lut_upd_e upd
);
  // Reset outranks a shift request in the same cycle.
  always_comb begin
    if (rst)         upd = UPD_INIT;
    else if (cfg_en) upd = UPD_SHIFT;
    else             upd = UPD_HOLD;
  end
endmodule

// File: rtl/lut_shift_store.sv
module lut_shift_store
  import serial_lut_pkg::*;
#(
  parameter int unsigned ENTRIES = LUT_ENTRIES,
  parameter logic [ENTRIES-1:0] INIT_BITS = '0
)(
  input  logic               clk,
  input  lut_upd_e           upd,
  input  logic               din,
  output logic [ENTRIES-1:0] cells
);
  // Each cell takes its lower neighbour; cell 0 takes the serial bit.
  for (genvar k = 0; k < ENTRIES; k++) begin : g_cell
    logic nbr;
    if (k == 0) begin : g_head
      assign nbr = din;
    end else begin : g_body
      assign nbr = cells[k-1];
    end

    always_ff @(posedge clk) begin
      case (upd)
        UPD_INIT:  cells[k] <= INIT_BITS[k];
        UPD_SHIFT: cells[k] <= nbr;
        default:   cells[k] <= cells[k];
      endcase
    end
  end
endmodule

// File: rtl/lut_read_mux.sv
module lut_read_mux #(
  parameter int unsigned ENTRIES = 16,
  localparam int unsigned SEL_W  = $clog2(ENTRIES)
)(
  input  logic [ENTRIES-1:0] cells,
  input  logic [SEL_W-1:0]   sel,
  output logic               bit_out
);
  always_comb begin
    bit_out = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (sel == SEL_W'(i)) bit_out = cells[i];
    end
  end
endmodule

// File: rtl/serial_lut.sv
module serial_lut
  import serial_lut_pkg::*;
#(
  parameter int unsigned ENTRIES = LUT_ENTRIES,
  parameter logic [ENTRIES-1:0] INIT_BITS = 16'h5AC0,
  localparam int unsigned SEL_W = $clog2(ENTRIES)
)(
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  input  logic             cfg_en,
  input  logic             cfg_din,
  output logic             lut_out,
  output logic             cascade_out
);
  lut_upd_e           upd;
  logic [ENTRIES-1:0] table_q;

  lut_update_ctrl u_ctrl (
    .rst    (rst),
    .cfg_en (cfg_en),
    .upd    (upd)
  );

  lut_shift_store #(
    .ENTRIES   (ENTRIES),
    .INIT_BITS (INIT_BITS)
  ) u_store (
    .clk   (clk),
    .upd   (upd),
    .din   (cfg_din),
    .cells (table_q)
  );

  lut_read_mux #(
    .ENTRIES (ENTRIES)
  ) u_mux (
    .cells   (table_q),
    .sel     (sel),
    .bit_out (lut_out)
  );

  assign cascade_out = table_q[ENTRIES-1];
endmodule

// File: rtl/serial_lut_chk.sv
module serial_lut_chk #(
  parameter int unsigned ENTRIES = 16,
  parameter logic [ENTRIES-1:0] INIT_BITS = '0,
  localparam int unsigned SEL_W = $clog2(ENTRIES)
)(
  input logic               clk,
  input logic               rst,
  input logic [SEL_W-1:0]   sel,
  input logic               cfg_en,
  input logic               cfg_din,
  input logic               lut_out,
  input logic               cascade_out,
  input logic [ENTRIES-1:0] table_q
);
  // R1: a reset cycle leaves the parameter contents behind it.
  assert_reset_load_R1: assert property (@(posedge clk)
    (rst && !cfg_en) |=> (table_q == INIT_BITS));

  // R6: reset beats a simultaneous shift request.
  assert_reset_priority_R6: assert property (@(posedge clk)
    (rst && cfg_en) |=> (table_q == INIT_BITS));

  // R2: the read path follows the stored bit at the selected row.
  always_comb begin
    if (!$isunknown(table_q) && !$isunknown(sel))
      assert_read_row_R2: assert (lut_out == table_q[sel]);
  end

  // R3: an enabled edge moves every entry up by one place.
  assert_shift_step_R3: assert property (@(posedge clk) disable iff (rst)
    cfg_en |=> (table_q == {$past(table_q[ENTRIES-2:0]), $past(cfg_din)}));

  // R4: during a load the cascade output picks up the former entry 14.
  assert_cascade_R4: assert property (@(posedge clk) disable iff (rst)
    (cfg_en && (sel == SEL_W'(ENTRIES-2))) |=> (cascade_out == $past(lut_out)));

  // R5: the contents hold while the enable is low.
  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |=> $stable(table_q));
endmodule

bind serial_lut serial_lut_chk #(
  .ENTRIES   (ENTRIES),
  .INIT_BITS (INIT_BITS)
) i_serial_lut_chk (
  .clk         (clk),
  .rst         (rst),
  .sel         (sel),
  .cfg_en      (cfg_en),
  .cfg_din     (cfg_din),
  .lut_out     (lut_out),
  .cascade_out (cascade_out),
  .table_q     (table_q)
);

// File: tb/test_serial_lut.sv
module test_serial_lut;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] INIT = 16'h5AC0;  // entries 0..3 are all zero

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] sel = 4'd0;
  logic cfg_en = 1'b0;
  logic cfg_din = 1'b0;
  logic lut_out, cascade_out;

  int checks = 0;
  int errors = 0;
  bit model[$];
  bit supplied[16];

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_lut #(.ENTRIES(16), .INIT_BITS(INIT)) i_serial_lut (
    .clk(clk), .rst(rst), .sel(sel), .cfg_en(cfg_en), .cfg_din(cfg_din),
    .lut_out(lut_out), .cascade_out(cascade_out)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s sel=%0d actual=%b expected=%b", tag, sel, act, exp);
    end
  endtask

  task automatic model_init();
    model.delete();
    for (int k = 0; k < 16; k++) model.push_back(INIT[k]);
  endtask

  // One clock: drive inputs, step the model at the edge, compare after it.
  task automatic tick(input logic r, input logic e, input logic d, input string tag);
    rst = r; cfg_en = e; cfg_din = d;
    @(posedge clk);
    if (r) model_init();
    else if (e) begin
      model.push_front(d);
      void'(model.pop_back());
    end
    #1;
    check({tag, " R8 read"}, lut_out, model[sel]);
    check({tag, " R4 cascade"}, cascade_out, model[15]);
  endtask

  task automatic sweep(input string tag);
    for (int s = 0; s < 16; s++) begin
      sel = 4'(s);
      #1;
      check({tag, " R2 row"}, lut_out, model[s]);
    end
  endtask

  initial begin
    model_init();
    tick(1'b1, 1'b0, 1'b0, "R1 reset");
    tick(1'b0, 1'b0, 1'b0, "R1 idle");
    sweep("R1 reset contents");
    sel = 4'b0001; #1;
    check("R2 select 0001 gives entry 1", lut_out, INIT[1]);

    // R5: serial input toggles with the enable low.
    for (int i = 0; i < 6; i++) tick(1'b0, 1'b0, 1'(i), "R5 hold");
    sweep("R5 after idle toggling");

    // R9 / R3 / R8: rows 0 and 1 start equal and diverge after one shift.
    sel = 4'd0; #1;
    check("R9 rows equal before load", lut_out, 1'b0);
    tick(1'b0, 1'b1, 1'b1, "R3 shift one");
    check("R3 entry0 takes serial bit", lut_out, 1'b1);
    sel = 4'd1; #1;
    check("R9 row 1 keeps old entry 0", lut_out, 1'b0);
    cfg_en = 1'b0;

    // R7: full sixteen-bit load.
    for (int i = 0; i < 16; i++) begin
      supplied[i] = 1'((16'h3C96 >> i) & 16'h1);
      sel = 4'(i);
      tick(1'b0, 1'b1, supplied[i], "R7 load");
    end
    cfg_en = 1'b0;
    for (int k = 0; k < 16; k++) begin
      sel = 4'(k); #1;
      check("R7 entry k holds bit from k edges back", lut_out, supplied[15-k]);
    end

    // R6: reset together with enable.
    sel = 4'd15;
    tick(1'b1, 1'b1, 1'b1, "R6 reset over shift");
    tick(1'b0, 1'b0, 1'b0, "R6 idle");
    sweep("R6 contents after reset");

    // Continuous enable: the table keeps repopulating.
    for (int i = 0; i < 40; i++) begin
      sel = 4'((i * 7) % 16);
      tick(1'b0, 1'b1, 1'(((i * 13) >> 2) & 1), "R3 continuous");
    end
    tick(1'b0, 1'b0, 1'b0, "R5 stop");
    sweep("R3 after continuous load");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule